// File: doc/BRIEF.md
# I/O Interruption Subclass Pending Queue

This block holds pending I/O interruption requests until a consumer takes them. It keeps one stack per interruption subclass and one pending bit per subclass. Each request carries a 16-bit subchannel id, a 16-bit subchannel number, a 32-bit parameter and a 32-bit interruption word. The word selects the subclass that the request is filed under.

A consumer presents an 8-bit enable mask and asks for one request. The block serves the lowest-numbered enabled subclass that holds anything, and within that subclass it serves the most recently filed request. A purge command removes every filed request, in any subclass, that carries a given id/number pair. A combinational has-work output tells the consumer whether a dequeue with the current mask would succeed. The stacks are small on-chip register arrays of parameterised depth. A request sent to a full stack is dropped, and a sticky flag records the loss.

Top module: `irq_subclass_queue`

## Requirements
- R1: An injected request is filed under subclass inj_word[29:27], and pending bit i goes high the cycle after a request is filed under subclass i.
- R2: Within one subclass, requests leave in reverse order of arrival (newest first).
- R3: A dequeue serves the lowest-numbered subclass that is both non-empty and enabled, where deq_mask bit i enables subclass i.
- R4: A dequeue with no enabled non-empty subclass pulses deq_empty for one cycle and changes no queue content.
- R5: A successful dequeue pulses deq_valid for exactly the cycle after deq_req, with the id, number, parameter and word of the served request.
- R6: A purge removes every request in all subclasses whose id and number both equal clr_sch_id and clr_sch_nr. A request that matches only one of the two is kept.
- R7: Pending bit i drops as soon as subclass i becomes empty, whether by dequeue or by purge.
- R8: A request sent to a subclass already holding DEPTH entries is dropped, and overflow goes high and stays high until reset.
- R9: has_work equals the OR over i of pending[i] AND deq_mask[i], combinationally.
- R10: At most one command is accepted per cycle, in priority purge, then dequeue, then inject. Lower-priority commands in the same cycle are ignored.
- R11: Synchronous reset empties all subclasses and clears pending, overflow, deq_valid and deq_empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_req | input | 1 | File a request |
| inj_sch_id | input | 16 | Subchannel id of the request |
| inj_sch_nr | input | 16 | Subchannel number of the request |
| inj_parm | input | 32 | Interruption parameter |
| inj_word | input | 32 | Interruption word; bits 29:27 give the subclass |
| deq_req | input | 1 | Take one request |
| deq_mask | input | 8 | Subclass enable mask, bit i for subclass i |
| clr_req | input | 1 | Purge matching requests |
| clr_sch_id | input | 16 | Id to purge |
| clr_sch_nr | input | 16 | Number to purge |
| deq_valid | output | 1 | One-cycle pulse: a request is on the deq_* outputs |
| deq_empty | output | 1 | One-cycle pulse: the dequeue found nothing eligible |
| deq_sch_id | output | 16 | Id of the served request |
| deq_sch_nr | output | 16 | Number of the served request |
| deq_parm | output | 32 | Parameter of the served request |
| deq_word | output | 32 | Interruption word of the served request |
| pending | output | 8 | Per-subclass non-empty bits |
| has_work | output | 1 | Some enabled subclass is pending |
| overflow | output | 1 | Sticky: a request was dropped on a full subclass |

## Verification
The bench targets the corner cases where a subtle bug would not show up as an obvious failure. It files several requests into one subclass and checks that they leave in reverse order; a design that kept them in arrival order would return the oldest request first. It masks off the only pending subclass and expects an empty result with the entry still there afterwards; a design that ignored the mask would serve the entry, and one that lost state on an empty dequeue would drop it. Purges are tested with one id/number pair spread over two subclasses and with a pair that matches only in id; a design that searched one subclass only, or compared only the id, would leave a stale request behind or remove the wrong one. Further cases cover a fifth request sent to a four-deep subclass, commands issued together in one cycle, and a reset in mid-use. These would catch a design that overwrote a full stack, let the losing command slip through, or kept entries across reset.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
  localparam int ID_W    = 16;
  localparam int NR_W    = 16;
  localparam int PARM_W  = 32;
  localparam int WORD_W  = 32;
  localparam int CLS_LSB = 27;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [NR_W-1:0]   nr;
    logic [PARM_W-1:0] parm;
    logic [WORD_W-1:0] word;
  } irq_entry_t;
endpackage

// File: rtl/irqq_stack.sv
module irqq_stack
  import irqq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic            clr,
  input  logic [ID_W-1:0] clr_id,
  input  logic [NR_W-1:0] clr_nr,
  input  irq_entry_t      din,
  output irq_entry_t      top,
  output logic            nonempty,
  output logic            full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  irq_entry_t      slots [DEPTH];
  irq_entry_t      squeezed [DEPTH];
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   kept_cnt;
  logic [AW-1:0]   top_idx;

  // Compaction for purge: survivors slide down, order preserved
  always_comb begin
    kept_cnt = '0;
    for (int i = 0; i < DEPTH; i++) squeezed[i] = slots[i];
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < cnt) && !((slots[i].id == clr_id) && (slots[i].nr == clr_nr))) begin
        squeezed[kept_cnt[AW-1:0]] = slots[i];
        kept_cnt = kept_cnt + 1'b1;
      end
    end
  end

  assign top_idx  = AW'(cnt - 1'b1);
  assign top      = slots[top_idx];
  assign nonempty = (cnt != '0);
  assign full     = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= squeezed[i];
      cnt <= kept_cnt;
    end else if (pop && nonempty) begin
      cnt <= cnt - 1'b1;
    end else if (push && !full) begin
      slots[cnt[AW-1:0]] <= din;
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> $stable(cnt));

  // R7
  last_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !clr && cnt == CW'(1)) |=> !nonempty);
endmodule

// File: rtl/irqq_pick.sv
module irqq_pick #(
  parameter int NCLS = 8,
  parameter int SW   = $clog2(NCLS)
) (
  input  logic [NCLS-1:0] req,
  output logic            hit,
  output logic [SW-1:0]   sel
);
  always_comb begin
    hit = |req;
    sel = '0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (req[i]) sel = SW'(i);
    end
  end
endmodule

// File: rtl/irq_subclass_queue.sv
module irq_subclass_queue
  import irqq_pkg::*;
#(
  parameter int NCLS  = 8,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inj_req,
  input  logic [ID_W-1:0]   inj_sch_id,
  input  logic [NR_W-1:0]   inj_sch_nr,
  input  logic [PARM_W-1:0] inj_parm,
  input  logic [WORD_W-1:0] inj_word,
  input  logic              deq_req,
  input  logic [NCLS-1:0]   deq_mask,
  input  logic              clr_req,
  input  logic [ID_W-1:0]   clr_sch_id,
  input  logic [NR_W-1:0]   clr_sch_nr,
  output logic              deq_valid,
  output logic              deq_empty,
  output logic [ID_W-1:0]   deq_sch_id,
  output logic [NR_W-1:0]   deq_sch_nr,
  output logic [PARM_W-1:0] deq_parm,
  output logic [WORD_W-1:0] deq_word,
  output logic [NCLS-1:0]   pending,
  output logic              has_work,
  output logic              overflow
);
  localparam int CLSW = $clog2(NCLS);

  logic            do_clr, do_deq, do_inj;
  logic [CLSW-1:0] inj_cls;
  logic [CLSW-1:0] pick_sel;
  logic            pick_hit;
  logic [NCLS-1:0] full_v;
  irq_entry_t      tops [NCLS];
  irq_entry_t      new_entry;

  assign do_clr    = clr_req;
  assign do_deq    = deq_req && !clr_req;
  assign do_inj    = inj_req && !clr_req && !deq_req;
  assign inj_cls   = inj_word[CLS_LSB +: CLSW];
  assign new_entry = '{id: inj_sch_id, nr: inj_sch_nr, parm: inj_parm, word: inj_word};
  assign has_work  = |(pending & deq_mask);

  irqq_pick #(.NCLS(NCLS), .SW(CLSW)) u_pick (
    .req (pending & deq_mask),
    .hit (pick_hit),
    .sel (pick_sel)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    irqq_stack #(.DEPTH(DEPTH)) u_stack (
      .clk      (clk),
      .rst      (rst),
      .push     (do_inj && (inj_cls == CLSW'(g))),
      .pop      (do_deq && pick_hit && (pick_sel == CLSW'(g))),
      .clr      (do_clr),
      .clr_id   (clr_sch_id),
      .clr_nr   (clr_sch_nr),
      .din      (new_entry),
      .top      (tops[g]),
      .nonempty (pending[g]),
      .full     (full_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deq_valid  <= 1'b0;
      deq_empty  <= 1'b0;
      overflow   <= 1'b0;
      deq_sch_id <= '0;
      deq_sch_nr <= '0;
      deq_parm   <= '0;
      deq_word   <= '0;
    end else begin
      deq_valid <= do_deq && pick_hit;
      deq_empty <= do_deq && !pick_hit;
      if (do_inj && full_v[inj_cls]) overflow <= 1'b1;
      if (do_deq && pick_hit) begin
        deq_sch_id <= tops[pick_sel].id;
        deq_sch_nr <= tops[pick_sel].nr;
        deq_parm   <= tops[pick_sel].parm;
        deq_word   <= tops[pick_sel].word;
      end
    end
  end

  // R5
  deq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    deq_valid |-> $past(deq_req && !clr_req));

  // R4
  deq_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(deq_valid && deq_empty));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R10
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (!deq_valid && !deq_empty));
endmodule

// File: tb/test_irq_subclass_queue.sv
`timescale 1ns/1ps
module test_irq_subclass_queue;
  logic        clk = 1'b0;
  logic        rst;
  logic        inj_req, deq_req, clr_req;
  logic [15:0] inj_sch_id, inj_sch_nr, clr_sch_id, clr_sch_nr;
  logic [31:0] inj_parm, inj_word;
  logic [7:0]  deq_mask;
  logic        deq_valid, deq_empty, has_work, overflow;
  logic [15:0] deq_sch_id, deq_sch_nr;
  logic [31:0] deq_parm, deq_word;
  logic [7:0]  pending;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_subclass_queue i_irq_subclass_queue (
    .clk(clk), .rst(rst),
    .inj_req(inj_req), .inj_sch_id(inj_sch_id), .inj_sch_nr(inj_sch_nr),
    .inj_parm(inj_parm), .inj_word(inj_word),
    .deq_req(deq_req), .deq_mask(deq_mask),
    .clr_req(clr_req), .clr_sch_id(clr_sch_id), .clr_sch_nr(clr_sch_nr),
    .deq_valid(deq_valid), .deq_empty(deq_empty),
    .deq_sch_id(deq_sch_id), .deq_sch_nr(deq_sch_nr),
    .deq_parm(deq_parm), .deq_word(deq_word),
    .pending(pending), .has_work(has_work), .overflow(overflow)
  );

  function automatic logic [31:0] W(input logic [2:0] cls, input logic [15:0] tag);
    return {2'b00, cls, 11'd0, tag};
  endfunction

  localparam logic [2:0] INJ = 3'b001, DEQ = 3'b010, CLR = 3'b100;

  typedef struct packed {
    logic [2:0]  ops;
    logic [15:0] tag;
    logic [31:0] arg;
    logic        ev;
    logic [31:0] ew;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{INJ, 16'h0001, W(3, 16'h0001), 1'b0, 32'd0},
    '{INJ, 16'h0002, W(3, 16'h0002), 1'b0, 32'd0},
    '{INJ, 16'h0003, W(1, 16'h0003), 1'b0, 32'd0},
    '{DEQ, 16'h0000, 32'h000000FF,   1'b1, W(1, 16'h0003)},
    '{DEQ, 16'h0000, 32'h000000FF,   1'b1, W(3, 16'h0002)},
    '{DEQ, 16'h0000, 32'h00000004,   1'b0, 32'd0},
    '{DEQ, 16'h0000, 32'h000000F7,   1'b0, 32'd0},
    '{DEQ, 16'h0000, 32'h00000008,   1'b1, W(3, 16'h0001)},
    '{DEQ, 16'h0000, 32'h000000FF,   1'b0, 32'd0},
    '{INJ, 16'h0010, W(7, 16'h0010), 1'b0, 32'd0},
    '{INJ, 16'h0011, W(5, 16'h0011), 1'b0, 32'd0},
    '{INJ, 16'h0012, W(7, 16'h0012), 1'b0, 32'd0},
    '{CLR, 16'h0010, 32'h0000FFEF,   1'b0, 32'd0},
    '{DEQ, 16'h0000, 32'h00000080,   1'b1, W(7, 16'h0012)},
    '{DEQ, 16'h0000, 32'h00000080,   1'b0, 32'd0},
    '{DEQ, 16'h0000, 32'h000000FF,   1'b1, W(5, 16'h0011)},
    '{INJ, 16'h0020, W(0, 16'h0020), 1'b0, 32'd0},
    '{INJ, 16'h0020, W(6, 16'h0020), 1'b0, 32'd0},
    '{INJ, 16'h0021, W(6, 16'h0021), 1'b0, 32'd0},
    '{INJ, 16'h0020, W(6, 16'h0020), 1'b0, 32'd0},
    '{CLR, 16'h0020, 32'h0000FFDF,   1'b0, 32'd0},
    '{DEQ, 16'h0000, 32'h000000FF,   1'b1, W(6, 16'h0021)},
    '{DEQ, 16'h0000, 32'h000000FF,   1'b0, 32'd0},
    '{DEQ, 16'h0000, 32'h00000041,   1'b0, 32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    inj_req = 0; deq_req = 0; clr_req = 0;
    inj_sch_id = 0; inj_sch_nr = 0; inj_parm = 0; inj_word = 0;
    deq_mask = 0; clr_sch_id = 0; clr_sch_nr = 0;
  endtask

  task automatic step(input logic [2:0] ops, input logic [15:0] tag,
                      input logic [31:0] word, input logic [7:0] mask,
                      input logic [15:0] cnr);
    @(negedge clk);
    inj_req = ops[0]; deq_req = ops[1]; clr_req = ops[2];
    inj_sch_id = tag; inj_sch_nr = ~tag; inj_parm = {~tag, tag}; inj_word = word;
    deq_mask = mask; clr_sch_id = tag; clr_sch_nr = cnr;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    #1;
    rst = 0;
  endtask

  task automatic expect_deq(input string req, input logic [31:0] ew);
    chk(req, {31'd0, deq_valid}, 32'd1);
    chk(req, deq_word, ew);
    chk(req, {16'd0, deq_sch_id}, {16'd0, ew[15:0]});
    chk(req, {16'd0, deq_sch_nr}, {16'd0, ~ew[15:0]});
    chk(req, deq_parm, {~ew[15:0], ew[15:0]});
  endtask

  task automatic expect_none(input string req);
    chk(req, {30'd0, deq_valid, deq_empty}, 32'd1);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    // R11 reset state
    chk("R11 pending", {24'd0, pending}, 32'd0);
    chk("R11 flags", {28'd0, deq_valid, deq_empty, overflow, has_work}, 32'd0);

    // Vector table: R1 R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      step(TBL[k].ops, TBL[k].tag, TBL[k].arg, TBL[k].arg[7:0], TBL[k].arg[15:0]);
      if (TBL[k].ops == INJ) begin
        chk("R1 pending set", {31'd0, pending[TBL[k].arg[29:27]]}, 32'd1);
      end else if (TBL[k].ops == DEQ) begin
        if (TBL[k].ev) expect_deq("R2 R3 R5 dequeue", TBL[k].ew);
        else expect_none("R4 R6 empty");
      end
    end
    // R7 everything drained
    chk("R7 pending after drain", {24'd0, pending}, 32'd0);

    // R5 pulse lasts one cycle
    step(INJ, 16'h0030, W(2, 16'h0030), 8'h00, 16'h0000);
    step(DEQ, 16'h0000, 32'd0, 8'hFF, 16'h0000);
    expect_deq("R5 served", W(2, 16'h0030));
    @(posedge clk); #1;
    chk("R5 one-cycle pulse", {31'd0, deq_valid}, 32'd0);

    // R6 partial match kept
    step(INJ, 16'h0040, W(4, 16'h0040), 8'h00, 16'h0000);
    step(CLR, 16'h0040, 32'd0, 8'h00, 16'h1234);
    chk("R6 partial match kept", {31'd0, pending[4]}, 32'd1);
    // R9 has_work with mask
    @(negedge clk); deq_mask = 8'h10; #1;
    chk("R9 has_work enabled", {31'd0, has_work}, 32'd1);
    deq_mask = 8'hEF; #1;
    chk("R9 has_work masked", {31'd0, has_work}, 32'd0);
    deq_mask = 8'h00;
    // R10 purge wins over dequeue
    step(CLR | DEQ, 16'h0999, 32'd0, 8'hFF, 16'h0999);
    chk("R10 deq ignored under clr", {30'd0, deq_valid, deq_empty}, 32'd0);
    chk("R10 entry kept", {31'd0, pending[4]}, 32'd1);
    // R7 purge empties subclass
    step(CLR, 16'h0040, 32'd0, 8'h00, 16'hFFBF);
    chk("R7 pending cleared by purge", {24'd0, pending}, 32'd0);
    // R10 dequeue wins over inject
    step(DEQ | INJ, 16'h0050, W(0, 16'h0050), 8'hFF, 16'h0000);
    expect_none("R10 deq first");
    chk("R10 inject ignored", {24'd0, pending}, 32'd0);

    // R8 overflow on a full subclass
    chk("R8 overflow low", {31'd0, overflow}, 32'd0);
    for (int t = 1; t <= 5; t++) step(INJ, 16'(t), W(2, 16'(t)), 8'h00, 16'h0000);
    chk("R8 overflow set", {31'd0, overflow}, 32'd1);
    for (int t = 4; t >= 1; t--) begin
      step(DEQ, 16'h0000, 32'd0, 8'h04, 16'h0000);
      expect_deq("R8 R2 kept entries", W(2, 16'(t)));
    end
    step(DEQ, 16'h0000, 32'd0, 8'h04, 16'h0000);
    expect_none("R8 fifth dropped");
    chk("R8 overflow sticky", {31'd0, overflow}, 32'd1);

    // R11 reset in mid-use
    step(INJ, 16'h0060, W(4, 16'h0060), 8'h00, 16'h0000);
    do_reset();
    chk("R11 pending after reset", {24'd0, pending}, 32'd0);
    chk("R11 overflow after reset", {31'd0, overflow}, 32'd0);
    step(DEQ, 16'h0000, 32'd0, 8'hFF, 16'h0000);
    expect_none("R11 queues emptied");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule